// File: doc/BRIEF.md
# Peripheral I/O Address Decoder

The decoder sits behind a 512 KB memory-mapped I/O window. It splits each host access into a target peripheral port and a register index. A host drives an offset, write data, an access size and a write or read strobe for one cycle. In that same cycle the decoder raises the strobe and select of exactly one of eight peripheral ports. Those ports are: control/interrupt registers, DMA register file, SCSI, serial, sound control, floppy, microcontroller link and NVRAM. It also presents a register index formed from the offset, in the way that port expects.

The selected port returns its read data combinationally. The decoder registers the result and answers the host one cycle later with an acknowledge, the read data and a flag that marks an access to unmapped space.

The serial port is reachable through two windows. The native window uses a 16-byte stride. The compatible window packs its registers at a 2-byte stride and translates the index through a 16-entry table that is fixed at elaboration time. Outside the first 16 bytes, the compatible window behaves like the native one.

Top module: `mio_addr_decode`

## Requirements
- R1: While rst_ni is low, rsp_ack_o, rsp_unmapped_o and rsp_rdata_o are all zero.
- R2: Every cycle with req_we_i or req_re_i high is answered by rsp_ack_o high in the following cycle. A cycle with neither strobe high is followed by rsp_ack_o low.
- R3: The sub-region is offset[18:12], and tgt_sel_o is one-hot on the target bit. The mapping is: 0x00 to bit 0 (control), 0x08 to bit 1 (DMA), 0x10 to bit 2 (SCSI), 0x12 and 0x13 to bit 3 (serial), 0x14 to bit 4 (sound), 0x15 to bit 5 (floppy), 0x16 and 0x17 to bit 6 (microcontroller), and 0x60 through 0x7F to bit 7 (NVRAM).
- R4: tgt_idx_o is set per target, zero-extended. Control uses offset[7:0]. SCSI, floppy and native serial (0x13) use offset[7:4]. Sound uses offset minus 0x14000. The microcontroller uses (offset minus 0x16000) shifted right by 9. NVRAM uses (offset minus 0x60000) shifted right by 4.
- R5: In sub-region 0x12, when offset[7:0] < 16, the serial index is entry offset[4:1] of the SER_MAP table (entry i occupies bits 4i+3:4i). Otherwise the index is offset[7:4]. The default table maps i to {i[0], i[3:1]}.
- R6: In sub-region 0x08, the DMA channel is offset[11:8]. Only channel DMA_CH (default 8) is mapped, with index offset[7:0]. Any other channel is unmapped.
- R7: An access to any other sub-region or DMA channel asserts no select and no target strobe. One cycle later it returns rsp_rdata_o of zero together with rsp_unmapped_o high for one cycle.
- R8: A mapped read returns, one cycle later, the tgt_rdata_i slice (bits 32t+31:32t) of the selected target t. A write returns rsp_rdata_o of zero.
- R9: In the request cycle, tgt_we_o and tgt_re_o equal the host strobes when the access is mapped. tgt_wdata_o and tgt_size_o follow req_wdata_i and req_size_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | 19 | Byte offset inside the window |
| req_wdata_i | input | 32 | Host write data |
| req_we_i | input | 1 | Write strobe, one cycle per access |
| req_re_i | input | 1 | Read strobe, one cycle per access |
| req_size_i | input | 2 | Access size code, passed through |
| tgt_sel_o | output | 8 | One-hot target select |
| tgt_idx_o | output | 16 | Register index for the selected target |
| tgt_we_o | output | 1 | Write strobe to the selected target |
| tgt_re_o | output | 1 | Read strobe to the selected target |
| tgt_wdata_o | output | 32 | Write data to targets |
| tgt_size_o | output | 2 | Access size to targets |
| tgt_rdata_i | input | 256 | Read data from all eight targets, 32 bits each |
| rsp_ack_o | output | 1 | Registered acknowledge |
| rsp_rdata_o | output | 32 | Registered read data |
| rsp_unmapped_o | output | 1 | Registered unmapped-access flag |

## Verification
Select, index, target strobes and pass-through data are combinational. They are due in the same cycle as the host strobe, so the bench samples them 1 ns after driving on the falling edge. Acknowledge, read data and the unmapped flag each pass one register. They are sampled on the next falling edge, after exactly one rising edge. At the start of every access, the bench confirms that the acknowledge is low after an idle cycle. The sweep covers all 128 sub-regions, each with a set of low offsets that includes the compatible serial window and every DMA channel.

// File: rtl/mio_pkg.sv
package mio_pkg;
  localparam int unsigned NUM_TGT = 8;

  typedef enum logic [2:0] {
    TGT_CTRL = 3'd0,
    TGT_DMA  = 3'd1,
    TGT_SCSI = 3'd2,
    TGT_SER  = 3'd3,
    TGT_SND  = 3'd4,
    TGT_FLOP = 3'd5,
    TGT_MCU  = 3'd6,
    TGT_NVR  = 3'd7
  } tgt_e;

  // entry i -> {i[0], i[3:1]}
  function automatic logic [63:0] default_ser_map();
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] v;
      v = 4'(i);
      m[i*4 +: 4] = {v[0], v[3:1]};
    end
    return m;
  endfunction
endpackage

// File: rtl/mio_ser_remap.sv
module mio_ser_remap #(
  parameter int unsigned   SEL_W   = 4,
  parameter logic [63:0]   SER_MAP = mio_pkg::default_ser_map()
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [3:0]       idx_o
);
  assign idx_o = SER_MAP[{sel_i, 2'b00} +: 4];
endmodule

// File: rtl/mio_region_decode.sv
module mio_region_decode
  import mio_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned DMA_CH = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        compat_idx_i,
  output tgt_e              tgt_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o
);
  localparam int unsigned SUB_LSB  = 12;
  localparam int unsigned SUB_W    = ADDR_W - SUB_LSB;
  localparam logic [SUB_W-1:0] NVR_BASE = SUB_W'(7'h60);

  logic [SUB_W-1:0] sub;
  assign sub = addr_i[ADDR_W-1:SUB_LSB];

  always_comb begin
    hit_o = 1'b1;
    tgt_o = TGT_CTRL;
    idx_o = '0;
    case (sub)
      SUB_W'(7'h00): idx_o = IDX_W'(addr_i[7:0]);
      SUB_W'(7'h08): begin
        tgt_o = TGT_DMA;
        hit_o = (addr_i[11:8] == 4'(DMA_CH));
        idx_o = IDX_W'(addr_i[7:0]);
      end
      SUB_W'(7'h10): begin
        tgt_o = TGT_SCSI;
        idx_o = IDX_W'(addr_i[7:4]);
      end
      SUB_W'(7'h12): begin
        tgt_o = TGT_SER;
        idx_o = (addr_i[7:4] == 4'h0) ? IDX_W'(compat_idx_i) : IDX_W'(addr_i[7:4]);
      end
      SUB_W'(7'h13): begin
        tgt_o = TGT_SER;
        idx_o = IDX_W'(addr_i[7:4]);
      end
      SUB_W'(7'h14): begin
        tgt_o = TGT_SND;
        idx_o = IDX_W'(addr_i[11:0]);
      end
      SUB_W'(7'h15): begin
        tgt_o = TGT_FLOP;
        idx_o = IDX_W'(addr_i[7:4]);
      end
      SUB_W'(7'h16), SUB_W'(7'h17): begin
        tgt_o = TGT_MCU;
        idx_o = IDX_W'(addr_i[12:9]);
      end
      default: begin
        if (sub >= NVR_BASE) begin
          tgt_o = TGT_NVR;
          idx_o = IDX_W'(addr_i[16:4]);
        end else begin
          hit_o = 1'b0;
        end
      end
    endcase
  end
endmodule

// File: rtl/mio_rdata_mux.sv
module mio_rdata_mux #(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [NUM_TGT-1:0]        sel_i,
  input  logic [NUM_TGT*DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0]         data_o
);
  logic [DATA_W-1:0] masked [NUM_TGT];

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_mask
    assign masked[g] = bus_i[g*DATA_W +: DATA_W] & {DATA_W{sel_i[g]}};
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_TGT; i++) data_o = data_o | masked[i];
  end
endmodule

// File: rtl/mio_addr_decode.sv
module mio_addr_decode
  import mio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 16,
  parameter int unsigned SIZE_W  = 2,
  parameter int unsigned DMA_CH  = 8,
  parameter logic [63:0] SER_MAP = mio_pkg::default_ser_map()
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           req_addr_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  input  logic                        req_we_i,
  input  logic                        req_re_i,
  input  logic [SIZE_W-1:0]           req_size_i,
  output logic [NUM_TGT-1:0]          tgt_sel_o,
  output logic [IDX_W-1:0]            tgt_idx_o,
  output logic                        tgt_we_o,
  output logic                        tgt_re_o,
  output logic [DATA_W-1:0]           tgt_wdata_o,
  output logic [SIZE_W-1:0]           tgt_size_o,
  input  logic [NUM_TGT*DATA_W-1:0]   tgt_rdata_i,
  output logic                        rsp_ack_o,
  output logic [DATA_W-1:0]           rsp_rdata_o,
  output logic                        rsp_unmapped_o
);
  logic       req;
  logic       hit;
  tgt_e       tgt;
  logic [3:0] compat_idx;
  logic [DATA_W-1:0] mux_data;

  assign req = req_we_i | req_re_i;

  mio_ser_remap #(.SEL_W(4), .SER_MAP(SER_MAP)) u_remap (
    .sel_i (req_addr_i[4:1]),
    .idx_o (compat_idx)
  );

  mio_region_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DMA_CH(DMA_CH)) u_dec (
    .addr_i       (req_addr_i),
    .compat_idx_i (compat_idx),
    .tgt_o        (tgt),
    .idx_o        (tgt_idx_o),
    .hit_o        (hit)
  );

  always_comb begin
    tgt_sel_o = '0;
    if (req && hit) tgt_sel_o[int'(tgt)] = 1'b1;
  end

  assign tgt_we_o    = req_we_i & hit;
  assign tgt_re_o    = req_re_i & hit;
  assign tgt_wdata_o = req_wdata_i;
  assign tgt_size_o  = req_size_i;

  mio_rdata_mux #(.NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_mux (
    .sel_i  (tgt_sel_o),
    .bus_i  (tgt_rdata_i),
    .data_o (mux_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_ack_o      <= 1'b0;
      rsp_unmapped_o <= 1'b0;
      rsp_rdata_o    <= '0;
    end else begin
      rsp_ack_o      <= req;
      rsp_unmapped_o <= req & ~hit;
      rsp_rdata_o    <= tgt_re_o ? mux_data : '0;
    end
  end
endmodule

// File: rtl/mio_addr_decode_chk.sv
module mio_addr_decode_chk #(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned DATA_W  = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_we_i,
  input logic               req_re_i,
  input logic [NUM_TGT-1:0] tgt_sel_o,
  input logic               tgt_we_o,
  input logic               tgt_re_o,
  input logic               rsp_ack_o,
  input logic [DATA_W-1:0]  rsp_rdata_o,
  input logic               rsp_unmapped_o
);
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_i || req_re_i) |=> rsp_ack_o); // R2
  AST_NO_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_we_i || req_re_i) |=> !rsp_ack_o); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_sel_o)); // R3
  AST_UNMAPPED_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_i || req_re_i) && tgt_sel_o == '0 |=> rsp_unmapped_o); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_unmapped_o |-> rsp_rdata_o == '0 && rsp_ack_o); // R7
  AST_WRITE_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_we_i && !req_re_i |=> rsp_rdata_o == '0); // R8
  AST_STROBE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_we_o || tgt_re_o) |-> tgt_sel_o != '0); // R9
endmodule

bind mio_addr_decode mio_addr_decode_chk #(.NUM_TGT(NUM_TGT), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_we_i       (req_we_i),
  .req_re_i       (req_re_i),
  .tgt_sel_o      (tgt_sel_o),
  .tgt_we_o       (tgt_we_o),
  .tgt_re_o       (tgt_re_o),
  .rsp_ack_o      (rsp_ack_o),
  .rsp_rdata_o    (rsp_rdata_o),
  .rsp_unmapped_o (rsp_unmapped_o)
);

// File: tb/mio_addr_decode_bench.sv
`timescale 1ns/1ps
module mio_addr_decode_bench;
  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [18:0]   req_addr;
  logic [31:0]   req_wdata;
  logic          req_we, req_re;
  logic [1:0]    req_size;
  logic [NT-1:0] tgt_sel;
  logic [15:0]   tgt_idx;
  logic          tgt_we, tgt_re;
  logic [31:0]   tgt_wdata;
  logic [1:0]    tgt_size;
  logic [NT*32-1:0] stub;
  logic          rsp_ack, rsp_unmapped;
  logic [31:0]   rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // peripheral stubs: data = C0 | target<<24 | index
  always_comb
    for (int t = 0; t < NT; t++) stub[t*32 +: 32] = 32'hC000_0000 | (32'(t) << 24) | 32'(tgt_idx);

  mio_addr_decode u_mio_addr_decode (
    .clk_i(clk), .rst_ni(rst_n),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_we_i(req_we), .req_re_i(req_re),
    .req_size_i(req_size),
    .tgt_sel_o(tgt_sel), .tgt_idx_o(tgt_idx), .tgt_we_o(tgt_we), .tgt_re_o(tgt_re),
    .tgt_wdata_o(tgt_wdata), .tgt_size_o(tgt_size), .tgt_rdata_i(stub),
    .rsp_ack_o(rsp_ack), .rsp_rdata_o(rsp_rdata), .rsp_unmapped_o(rsp_unmapped)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [18:0] a, output bit hit, output int tgt, output int idx);
    int sub, off;
    sub = int'(a[18:12]);
    off = int'(a);
    hit = 1; tgt = 0; idx = 0;
    if (sub == 0) begin tgt = 0; idx = off & 255; end
    else if (sub == 8) begin
      int d;
      d = off - 'h8000;
      tgt = 1; idx = d & 255;
      if ((d >> 8) != 8) hit = 0;
    end
    else if (sub == 'h10) begin tgt = 2; idx = (off >> 4) & 15; end
    else if (sub == 'h12) begin
      tgt = 3;
      if ((off & 255) < 16) begin
        int c;
        c = (off >> 1) & 15;
        idx = ((c & 1) << 3) | (c >> 1);
      end else idx = (off >> 4) & 15;
    end
    else if (sub == 'h13) begin tgt = 3; idx = (off >> 4) & 15; end
    else if (sub == 'h14) begin tgt = 4; idx = off - 'h14000; end
    else if (sub == 'h15) begin tgt = 5; idx = (off >> 4) & 15; end
    else if (sub == 'h16 || sub == 'h17) begin tgt = 6; idx = (off - 'h16000) >> 9; end
    else if (sub >= 'h60) begin tgt = 7; idx = (off - 'h60000) >> 4; end
    else hit = 0;
  endfunction

  task automatic do_access(input logic [18:0] a, input bit wr);
    bit h; int t; int ix; int sub;
    logic [31:0] wd; logic [NT-1:0] es; logic [31:0] er;
    string tag_sel, tag_idx;
    model(a, h, t, ix);
    sub = int'(a[18:12]);
    wd = {13'h0, a} ^ 32'h5A5A_0000;
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R2", rsp_ack, 0);
    req_addr = a; req_wdata = wd; req_we = wr; req_re = !wr; req_size = a[1:0];
    #1;
    es = h ? NT'(1) << t : '0;
    tag_sel = (sub == 8) ? "R6" : (sub == 'h12) ? "R5" : !h ? "R7" : "R3";
    tag_idx = (sub == 8) ? "R6" : (sub == 'h12) ? "R5" : "R4";
    chk(tgt_sel == es, tag_sel, tgt_sel, es);
    if (h) chk(tgt_idx == 16'(ix), tag_idx, tgt_idx, ix);
    chk(tgt_we == (wr && h) && tgt_re == (!wr && h), h ? "R9" : "R7", {tgt_we, tgt_re}, {wr && h, !wr && h});
    chk(tgt_wdata == wd && tgt_size == a[1:0], "R9", tgt_wdata, wd);
    @(negedge clk);
    req_we = 0; req_re = 0;
    er = (h && !wr) ? (32'hC000_0000 | (32'(t) << 24) | 32'(ix)) : 32'h0;
    chk(rsp_ack == 1'b1, "R2", rsp_ack, 1);
    chk(rsp_unmapped == !h, "R7", rsp_unmapped, !h);
    chk(rsp_rdata == er, h ? "R8" : "R7", rsp_rdata, er);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_addr = '0; req_wdata = '0; req_we = 0; req_re = 0; req_size = '0;
    repeat (3) @(negedge clk);
    chk(rsp_ack == 0 && rsp_unmapped == 0 && rsp_rdata == 0, "R1",
        {rsp_ack, rsp_unmapped, rsp_rdata}, 0);
    rst_n = 1;
    for (int s = 0; s < 128; s++) begin
      for (int j = 0; j < 40; j++) begin
        int lo;
        if (j < 16) lo = j;
        else if (j < 24) lo = 'h800 | ((j * 37) & 255);
        else if (j < 36) lo = ((j - 24) << 8) | ((j * 13) & 255);
        else lo = (j * 'h9D3 + 'h15) & 'hFFF;
        do_access({7'(s), 12'(lo)}, 1'b0);
        do_access({7'(s), 12'(lo)}, 1'b1);
      end
    end
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R2", rsp_ack, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule